// File: doc/BRIEF.md
# Burst Launch and FIFO Load Controller

This block sits on the sending side of a point-to-point channel, between an external synchronous FIFO and the word serializer. It decides when a burst may begin and then pulls words out of the FIFO one per clock. A burst begins only when the link is up, the receiver has granted credit, the host offers a burst and the FIFO is not empty. From then on the burst runs without regard to those enables. It ends after a full count of words, or early as a short burst when the FIFO runs dry.

Every word loaded is shown on the word output one cycle later with a strobe. The block also keeps a running XOR of the burst's words. In the cycle after the last data word, it presents that checkword together with a one-cycle end pulse. A short burst disarms both enables. Each must then be seen low and then high again before another burst can begin. After a full-length burst the enables stay armed.

Top module: `burst_launch`

## Requirements
- R1: A burst starts in a cycle where the block is idle, link_up, dest_credit, host_burst_ok and fifo_not_empty are all high and both enables are armed. fifo_rd is high in that cycle, and din is loaded as the first word at the clock edge.
- R2: While host_burst_ok is low, no burst starts and fifo_rd stays low in the idle state.
- R3: Once a burst has started, changes on host_burst_ok, dest_credit or link_up have no effect on it. Loading and burst_active continue unchanged.
- R4: During a burst, fifo_rd equals fifo_not_empty. Every word loaded at an edge appears on word_out with word_stb high in the following cycle.
- R5: A burst that never sees an empty FIFO loads exactly BURST_LEN words. burst_active falls at the edge that loads the last one.
- R6: In the cycle after the last data word is shown, word_out carries the XOR of all the burst's words, burst_end is high for that single cycle and word_stb is low.
- R7: If fifo_not_empty is low in a cycle while a burst is active, the burst ends at that edge as a short burst. The next cycle shows burst_end with the checkword of the words loaded so far, and burst_active low.
- R8: After a short burst, no burst starts until host_burst_ok and fifo_not_empty have each been sampled low at a clock edge later than the ending edge. Levels that simply stay high do not restart a burst.
- R9: After a full-length burst, no start occurs in the cycle that shows the last data word. With both enables held high, a new burst may start in the burst_end cycle without re-arming.
- R10: An asynchronous active-low reset clears burst_active, word_stb, burst_end and word_out, aborts any burst and arms both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_burst_ok | input | 1 | Host offers a burst (level) |
| fifo_not_empty | input | 1 | FIFO holds at least one word |
| dest_credit | input | 1 | Receiver has credit for another burst |
| link_up | input | 1 | Connection established |
| din | input | DATA_W | FIFO read data |
| fifo_rd | output | 1 | Load/read enable for the FIFO in this cycle |
| burst_active | output | 1 | A burst is loading words |
| word_stb | output | 1 | word_out holds a data word |
| word_out | output | DATA_W | Data word, or checkword when burst_end is high |
| burst_end | output | 1 | One-cycle end of burst; checkword on word_out |

## Verification
The hardest case to reach from the ports is the re-arm rule after a short burst. The bench has to end a burst by dropping fifo_not_empty for exactly the ending edge. It then holds both enables high to show that no restart follows. After that it lowers each enable in a separate later cycle, so that one freshly armed enable alone is shown not to be enough. The stimulus table also drops host_burst_ok, credit and link during a burst. It holds the enables high across a full-length end to show the immediate restart there, and it ends with a single-word short burst whose checkword equals that word.

// File: rtl/burst_launch.sv
module burst_launch #(
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_burst_ok,
  input  logic              fifo_not_empty,
  input  logic              dest_credit,
  input  logic              link_up,
  input  logic [DATA_W-1:0] din,
  output logic              fifo_rd,
  output logic              burst_active,
  output logic              word_stb,
  output logic [DATA_W-1:0] word_out,
  output logic              burst_end
);
  localparam int CNT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

  logic              in_burst, end_pend, arm_b, arm_d;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] chk;

  wire start = !in_burst && !end_pend && link_up && dest_credit &&
               host_burst_ok && fifo_not_empty && arm_b && arm_d;
  wire take  = in_burst && fifo_not_empty;
  wire last  = take && (cnt == CNT_W'(BURST_LEN - 1));
  wire cut   = in_burst && !fifo_not_empty;

  assign fifo_rd      = start || take;
  assign burst_active = in_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst  <= 1'b0;
      end_pend  <= 1'b0;
      arm_b     <= 1'b1;
      arm_d     <= 1'b1;
      cnt       <= '0;
      chk       <= '0;
      word_stb  <= 1'b0;
      word_out  <= '0;
      burst_end <= 1'b0;
    end else begin
      if (start) begin
        in_burst <= 1'b1;
        cnt      <= CNT_W'(1);
        chk      <= din;
      end else if (take) begin
        cnt <= cnt + CNT_W'(1);
        chk <= chk ^ din;
        if (last) in_burst <= 1'b0;
      end else if (cut) begin
        in_burst <= 1'b0;
      end

      end_pend  <= last;
      burst_end <= cut || end_pend;
      word_stb  <= fifo_rd;
      if (fifo_rd)             word_out <= din;
      else if (cut || end_pend) word_out <= chk;

      if (cut)                 arm_b <= 1'b0;
      else if (!host_burst_ok) arm_b <= 1'b1;
      if (cut)                 arm_d <= 1'b0;
      else if (!fifo_not_empty) arm_d <= 1'b1;
    end
  end
endmodule

// File: rtl/burst_launch_chk.sv
module burst_launch_chk #(
  parameter int BURST_LEN = 256
) (
  input logic clk,
  input logic rst_n,
  input logic host_burst_ok,
  input logic fifo_not_empty,
  input logic dest_credit,
  input logic link_up,
  input logic fifo_rd,
  input logic burst_active,
  input logic word_stb,
  input logic burst_end
);
  logic [31:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wcnt <= '0;
    else if (fifo_rd)      wcnt <= burst_active ? wcnt + 32'd1 : 32'd1;
    else if (!burst_active) wcnt <= '0;
  end

  a_r4_rd_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_not_empty);

  a_r2_start_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !burst_active) |-> (host_burst_ok && dest_credit && link_up));

  a_r4_strobe_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> word_stb);

  a_r6_end_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> !word_stb);

  a_r7_short_end: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !fifo_not_empty) |=> (burst_end && !burst_active));

  a_r5_length_bound: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> (wcnt < BURST_LEN));
endmodule

bind burst_launch burst_launch_chk #(.BURST_LEN(BURST_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_burst_ok(host_burst_ok),
  .fifo_not_empty(fifo_not_empty), .dest_credit(dest_credit),
  .link_up(link_up), .fifo_rd(fifo_rd), .burst_active(burst_active),
  .word_stb(word_stb), .burst_end(burst_end)
);

// File: tb/burst_launch_tb_top.sv
`timescale 1ns/1ps
module burst_launch_tb_top;
  localparam int DW  = 16;
  localparam int LEN = 4;
  localparam int NV  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b = 1'b0, d = 1'b0, c = 1'b0, l = 1'b0;
  logic [DW-1:0] din = '0;
  logic rd, act, stb, endp;
  logic [DW-1:0] wout;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  burst_launch #(.DATA_W(DW), .BURST_LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_burst_ok(b), .fifo_not_empty(d),
    .dest_credit(c), .link_up(l), .din(din), .fifo_rd(rd),
    .burst_active(act), .word_stb(stb), .word_out(wout), .burst_end(endp)
  );

  // {bst,dat,credit,link, din, rd,active,stb,end, word}
  localparam logic [39:0] VEC [NV] = '{
    {4'b0111, 16'h0000, 4'b0000, 16'h0000}, // R2 enable low after reset
    {4'b1111, 16'h1111, 4'b1000, 16'h0000}, // R1 start
    {4'b0101, 16'h2222, 4'b1110, 16'h1111}, // R3 enable and credit drop
    {4'b1110, 16'h4444, 4'b1110, 16'h2222}, // R3 link drop
    {4'b1111, 16'h8888, 4'b1110, 16'h4444}, // R4 last load of full burst
    {4'b1111, 16'h9999, 4'b0010, 16'h8888}, // R5 R9 no start here
    {4'b1111, 16'h0101, 4'b1001, 16'hFFFF}, // R6 checkword, R9 restart
    {4'b1111, 16'h0202, 4'b1110, 16'h0101},
    {4'b1011, 16'h0000, 4'b0110, 16'h0202}, // R7 FIFO empty mid-burst
    {4'b1111, 16'h0000, 4'b0001, 16'h0303}, // R7 short end, R8 no restart
    {4'b1011, 16'h0000, 4'b0000, 16'h0000}, // R8 data low re-arms data
    {4'b1111, 16'h0000, 4'b0000, 16'h0000}, // R8 host not yet re-armed
    {4'b0111, 16'h0000, 4'b0000, 16'h0000}, // R8 host low re-arms
    {4'b1101, 16'h0A0A, 4'b0000, 16'h0000}, // R1 no credit
    {4'b1110, 16'h0A0A, 4'b0000, 16'h0000}, // R1 no link
    {4'b1111, 16'h0A0A, 4'b1000, 16'h0000}, // R1 start
    {4'b1011, 16'h0000, 4'b0110, 16'h0A0A}, // R7 single-word burst
    {4'b0011, 16'h0000, 4'b0001, 16'h0A0A}  // R6 checkword of one word
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", what, got, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset burst_active", act, 0);
    check("R10 reset word_stb", stb, 0);
    check("R10 reset burst_end", endp, 0);
    check("R10 reset word_out", wout, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {b, d, c, l} = VEC[i][39:36];
      din = VEC[i][35:20];
      #1;
      check($sformatf("R1/R4 fifo_rd row %0d", i), rd, VEC[i][19]);
      check($sformatf("R5 burst_active row %0d", i), act, VEC[i][18]);
      check($sformatf("R4 word_stb row %0d", i), stb, VEC[i][17]);
      check($sformatf("R6 burst_end row %0d", i), endp, VEC[i][16]);
      if (VEC[i][17] || VEC[i][16])
        check($sformatf("R6 word_out row %0d", i), wout, VEC[i][15:0]);
    end

    // R10: reset in the middle of a burst
    @(negedge clk);
    {b, d, c, l} = 4'b1111; din = 16'h5A5A;
    @(negedge clk);
    din = 16'h3C3C;
    #1;
    check("R10 burst running before reset", act, 1);
    rst_n = 1'b0;
    #1;
    check("R10 mid-burst reset burst_active", act, 0);
    check("R10 mid-burst reset word_stb", stb, 0);
    check("R10 mid-burst reset word_out", wout, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 armed after reset fifo_rd", rd, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule